// File: doc/BRIEF.md
# BCD Calendar Counter Chain

This block keeps wall-clock time and date as a chain of BCD counters: seconds, minutes, hours in 24-hour form, a weekday numbered 1 to 7, day of month, month and a two-digit year. A one-cycle tick from an external 1 Hz prescaler advances the seconds. Each field that rolls over carries into the next one. The day field knows the length of every month, including February in leap years.

A serial front end, which lies outside this block, uses two controls. A freeze input stops all counting while it is held. A commit strobe writes every field at once from a 52-bit word. The same 52-bit layout is presented continuously on a parallel snapshot output, so the front end can shift it out.

Top module: `cal_chain`

## Requirements
- R1: After reset the snapshot reads 00 seconds, 00 minutes, 00 hours, weekday 1, day 01, month 01 and year 00.
- R2: The 52-bit word holds BCD fields at fixed bit positions. Seconds are in [6:0], minutes in [14:8], hours in [21:16], weekday in [26:24], day in [33:28], month in [40:36] and year in [51:44]. The spare bits (7, 15, 22, 23, 27, 34, 35, 41, 42 and 43) read as 0, and the values loaded into them are ignored.
- R3: Seconds and minutes count 00 to 59 and wrap to 00 with a carry. Hours count 00 to 23 and wrap to 00 with a carry into the day.
- R4: The weekday advances on the same hour rollover that advances the day. It counts 1 to 7 and wraps from 7 to 1.
- R5: April, June, September and November end after day 30. All other months except February end after day 31. The day then returns to 01 and the month advances.
- R6: February ends after day 28, or after day 29 in a leap year. A year is leap when its value is divisible by 4, and year 00 counts as leap.
- R7: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R8: While freeze is high, a tick has no effect on any field.
- R9: A commit strobe loads every field from the load word on the next clock edge. The load takes priority over both tick and freeze.
- R10: Loaded values that are not valid are not repaired. For example, seconds loaded as 0x60 advance to 0x61 on the next tick.
- R11: Each clock cycle in which the tick is high, with no freeze and no load, advances the time by exactly one second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| freeze | input | 1 | Holds every counter while high |
| load_stb | input | 1 | Commit strobe for a bulk load |
| load_word | input | 52 | Field values to load (layout per R2) |
| snapshot | output | 52 | Current field values (layout per R2) |

## Verification
The bench goes after the ends of the calendar. It tests the year-end rollover from 99 to 00 together with the weekday wrap, the ends of 30-day months and the ends of 31-day months. February is checked in a plain year, a leap year and year 00. A design with a wrong leap test would skip February 29, or stop on it in a plain year. A design with a short carry chain would leave the month or year behind the day. Directed cases check that load beats tick and freeze, that freeze swallows ticks, and that out-of-range loads keep counting instead of being clamped. Long random runs that start near rollover points are compared, cycle by cycle, against a binary calendar model kept in the bench.

// File: rtl/cal_pkg.sv
package cal_pkg;
   localparam int WORD_W   = 52;
   localparam int SEC_LSB  = 0;
   localparam int SEC_W    = 7;
   localparam int MIN_LSB  = 8;
   localparam int MIN_W    = 7;
   localparam int HOUR_LSB = 16;
   localparam int HOUR_W   = 6;
   localparam int WDAY_LSB = 24;
   localparam int WDAY_W   = 3;
   localparam int DAY_LSB  = 28;
   localparam int DAY_W    = 6;
   localparam int MON_LSB  = 36;
   localparam int MON_W    = 5;
   localparam int YEAR_LSB = 44;
   localparam int YEAR_W   = 8;

   // Two-digit BCD increment; out-of-range digits simply keep counting.
   function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // Divisible by four on a BCD year: tens parity selects the unit set.
   function automatic logic bcd_div4(input logic [7:0] y);
      if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
      else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
   endfunction
endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
   parameter int           W     = 8,
   parameter logic [W-1:0] FIRST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic [W-1:0] last,
   output logic [W-1:0] val,
   output logic         wrap
);
   generate
      if (W < 1 || W > 8) begin : g_bad_width
         $error("cal_bcd_field: W must be 1..8");
      end
   endgenerate

   logic [7:0]   wide;
   logic [W-1:0] nxt;

   assign wide = 8'(val);
   assign nxt  = W'(cal_pkg::bcd_inc8(wide));
   assign wrap = step && (val == last);

   always_ff @(posedge clk) begin
      if (!rst_n)    val <= FIRST;
      else if (ld)   val <= ld_val;
      else if (step) val <= wrap ? FIRST : nxt;
   end

   AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (val == $past(ld_val))); // R9
   AST_FIELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !step) |=> $stable(val)); // R8
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len #(
   parameter bit LEAP_EN = 1'b1
) (
   input  logic [4:0] month,
   input  logic [7:0] year,
   output logic       leap,
   output logic [5:0] last_day
);
   generate
      if (LEAP_EN) begin : g_leap
         assign leap = cal_pkg::bcd_div4(year);
      end else begin : g_noleap
         logic unused_year;
         assign unused_year = ^year;
         assign leap = 1'b0;
      end
   endgenerate

   always_comb begin
      case (month)
         5'h02:                      last_day = leap ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: last_day = 6'h30;
         default:                    last_day = 6'h31;
      endcase
   end
endmodule

// File: rtl/cal_chain.sv
module cal_chain #(
   parameter int WORD_W     = 52,
   parameter bit LEAP_EN    = 1'b1,
   parameter int WDAY_FIRST = 1,
   parameter int WDAY_LAST  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              freeze,
   input  logic              load_stb,
   input  logic [WORD_W-1:0] load_word,
   output logic [WORD_W-1:0] snapshot
);
   import cal_pkg::*;

   generate
      if (WORD_W != cal_pkg::WORD_W || YEAR_LSB + YEAR_W != WORD_W) begin : g_bad_word
         $error("cal_chain: word width does not match field layout");
      end
      if (WDAY_FIRST < 1 || WDAY_LAST > 7 || WDAY_FIRST >= WDAY_LAST) begin : g_bad_wday
         $error("cal_chain: weekday range must lie in 1..7");
      end
   endgenerate

   localparam logic [WDAY_W-1:0] WD_FIRST = WDAY_W'(WDAY_FIRST);
   localparam logic [WDAY_W-1:0] WD_LAST  = WDAY_W'(WDAY_LAST);

   logic              adv;
   logic [SEC_W-1:0]  sec;
   logic [MIN_W-1:0]  mins;
   logic [HOUR_W-1:0] hour;
   logic [WDAY_W-1:0] wday;
   logic [DAY_W-1:0]  day;
   logic [MON_W-1:0]  mon;
   logic [YEAR_W-1:0] year;
   logic sec_wrap, min_wrap, hour_wrap, wday_wrap, day_wrap, mon_wrap, year_wrap;
   logic              leap;
   logic [DAY_W-1:0]  mon_last;

   assign adv = tick && !freeze && !load_stb;

   cal_bcd_field #(.W(SEC_W), .FIRST(7'h00)) i_sec (
      .clk(clk), .rst_n(rst_n), .step(adv), .ld(load_stb),
      .ld_val(load_word[SEC_LSB +: SEC_W]), .last(7'h59), .val(sec), .wrap(sec_wrap));

   cal_bcd_field #(.W(MIN_W), .FIRST(7'h00)) i_min (
      .clk(clk), .rst_n(rst_n), .step(sec_wrap), .ld(load_stb),
      .ld_val(load_word[MIN_LSB +: MIN_W]), .last(7'h59), .val(mins), .wrap(min_wrap));

   cal_bcd_field #(.W(HOUR_W), .FIRST(6'h00)) i_hour (
      .clk(clk), .rst_n(rst_n), .step(min_wrap), .ld(load_stb),
      .ld_val(load_word[HOUR_LSB +: HOUR_W]), .last(6'h23), .val(hour), .wrap(hour_wrap));

   cal_bcd_field #(.W(WDAY_W), .FIRST(WD_FIRST)) i_wday (
      .clk(clk), .rst_n(rst_n), .step(hour_wrap), .ld(load_stb),
      .ld_val(load_word[WDAY_LSB +: WDAY_W]), .last(WD_LAST), .val(wday), .wrap(wday_wrap));

   cal_month_len #(.LEAP_EN(LEAP_EN)) i_mlen (
      .month(mon), .year(year), .leap(leap), .last_day(mon_last));

   cal_bcd_field #(.W(DAY_W), .FIRST(6'h01)) i_day (
      .clk(clk), .rst_n(rst_n), .step(hour_wrap), .ld(load_stb),
      .ld_val(load_word[DAY_LSB +: DAY_W]), .last(mon_last), .val(day), .wrap(day_wrap));

   cal_bcd_field #(.W(MON_W), .FIRST(5'h01)) i_mon (
      .clk(clk), .rst_n(rst_n), .step(day_wrap), .ld(load_stb),
      .ld_val(load_word[MON_LSB +: MON_W]), .last(5'h12), .val(mon), .wrap(mon_wrap));

   cal_bcd_field #(.W(YEAR_W), .FIRST(8'h00)) i_year (
      .clk(clk), .rst_n(rst_n), .step(mon_wrap), .ld(load_stb),
      .ld_val(load_word[YEAR_LSB +: YEAR_W]), .last(8'h99), .val(year), .wrap(year_wrap));

   always_comb begin
      snapshot = '0;
      snapshot[SEC_LSB  +: SEC_W]  = sec;
      snapshot[MIN_LSB  +: MIN_W]  = mins;
      snapshot[HOUR_LSB +: HOUR_W] = hour;
      snapshot[WDAY_LSB +: WDAY_W] = wday;
      snapshot[DAY_LSB  +: DAY_W]  = day;
      snapshot[MON_LSB  +: MON_W]  = mon;
      snapshot[YEAR_LSB +: YEAR_W] = year;
   end

   AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !load_stb) |=> $stable(snapshot)); // R8
   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && sec == 7'h59) |=> (sec == 7'h00)); // R3
   AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      wday_wrap |=> (wday == WD_FIRST)); // R4
   AST_MONTH_30: assert property (@(posedge clk) disable iff (!rst_n)
      (hour_wrap && day == 6'h30 &&
       (mon == 5'h04 || mon == 5'h06 || mon == 5'h09 || mon == 5'h11))
      |=> (day == 6'h01)); // R5
   AST_FEB_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (hour_wrap && mon == 5'h02 && day == 6'h28 && !leap)
      |=> (day == 6'h01 && mon == 5'h03)); // R6
   AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      year_wrap |=> (year == 8'h00 && mon == 5'h01)); // R7
endmodule

// File: tb/test_cal_chain.sv
`timescale 1ns/1ps
module test_cal_chain;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        freeze = 1'b0;
   logic        load_stb = 1'b0;
   logic [51:0] load_word = '0;
   logic [51:0] snapshot;

   int total = 0;
   int bad = 0;
   int m_s, m_mi, m_h, m_w, m_d, m_mo, m_y;

   always #10 clk = ~clk;

   cal_chain i_cal_chain (
      .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze),
      .load_stb(load_stb), .load_word(load_word), .snapshot(snapshot));

   function automatic logic [7:0] to_bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int from_bcd(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic int dim(input int mo, input int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [51:0] pack(input int s, input int mi, input int h,
                                        input int w, input int d, input int mo, input int y);
      logic [51:0] r;
      r = '0;
      r[6:0]   = 7'(to_bcd(s));
      r[14:8]  = 7'(to_bcd(mi));
      r[21:16] = 6'(to_bcd(h));
      r[26:24] = 3'(w);
      r[33:28] = 6'(to_bcd(d));
      r[40:36] = 5'(to_bcd(mo));
      r[51:44] = to_bcd(y);
      return r;
   endfunction

   function automatic logic [51:0] model_word();
      return pack(m_s, m_mi, m_h, m_w, m_d, m_mo, m_y);
   endfunction

   task automatic model_load(input logic [51:0] v);
      m_s  = from_bcd(8'(v[6:0]));
      m_mi = from_bcd(8'(v[14:8]));
      m_h  = from_bcd(8'(v[21:16]));
      m_w  = int'(v[26:24]);
      m_d  = from_bcd(8'(v[33:28]));
      m_mo = from_bcd(8'(v[40:36]));
      m_y  = from_bcd(v[51:44]);
   endtask

   task automatic model_adv();
      m_s++;
      if (m_s == 60) begin
         m_s = 0; m_mi++;
         if (m_mi == 60) begin
            m_mi = 0; m_h++;
            if (m_h == 24) begin
               m_h = 0;
               m_w = (m_w == 7) ? 1 : m_w + 1;
               if (m_d == dim(m_mo, m_y)) begin
                  m_d = 1; m_mo++;
                  if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
               end else m_d++;
            end
         end
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic step(input logic t, input logic f, input logic l, input logic [51:0] w);
      tick = t; freeze = f; load_stb = l; load_word = w;
      @(posedge clk);
      if (l) model_load(w);
      else if (t && !f) model_adv();
      @(negedge clk);
      tick = 1'b0; freeze = 1'b0; load_stb = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [51:0] act, input logic [51:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic ld(input int s, input int mi, input int h, input int w,
                     input int d, input int mo, input int y);
      step(1'b0, 1'b0, 1'b1, pack(s, mi, h, w, d, mo, y));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [51:0] raw, spare, exp;
      void'($urandom(32'd4711));
      m_s = 0; m_mi = 0; m_h = 0; m_w = 1; m_d = 1; m_mo = 1; m_y = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset state", snapshot, pack(0, 0, 0, 1, 1, 1, 0));

      step(1'b1, 1'b0, 1'b0, '0);
      chk("R11 single tick", snapshot, pack(1, 0, 0, 1, 1, 1, 0));
      step(1'b1, 1'b1, 1'b0, '0);
      chk("R8 tick under freeze", snapshot, pack(1, 0, 0, 1, 1, 1, 0));
      step(1'b1, 1'b1, 1'b1, pack(59, 59, 23, 7, 31, 12, 99));
      chk("R9 load beats tick and freeze", snapshot, pack(59, 59, 23, 7, 31, 12, 99));
      step(1'b1, 1'b0, 1'b0, '0);
      chk("R7 year 99 to 00", snapshot, pack(0, 0, 0, 1, 1, 1, 0));
      chk("R4 weekday 7 to 1", 52'(snapshot[26:24]), 52'd1);

      ld(59, 59, 10, 3, 15, 6, 42);
      step(1'b1, 1'b0, 1'b0, '0);
      chk("R3 hour carry", snapshot, pack(0, 0, 11, 3, 15, 6, 42));
      ld(59, 59, 23, 2, 15, 6, 42);
      step(1'b1, 1'b0, 1'b0, '0);
      chk("R3 day carry from 23", snapshot, pack(0, 0, 0, 3, 16, 6, 42));

      ld(59, 59, 23, 5, 30, 4, 13);
      step(1'b1, 1'b0, 1'b0, '0);
      chk("R5 end of April", snapshot, pack(0, 0, 0, 6, 1, 5, 13));
      ld(59, 59, 23, 5, 30, 1, 13);
      step(1'b1, 1'b0, 1'b0, '0);
      chk("R5 January day 31 exists", snapshot, pack(0, 0, 0, 6, 31, 1, 13));
      ld(59, 59, 23, 5, 31, 1, 13);
      step(1'b1, 1'b0, 1'b0, '0);
      chk("R5 end of January", snapshot, pack(0, 0, 0, 6, 1, 2, 13));

      ld(59, 59, 23, 1, 28, 2, 1);
      step(1'b1, 1'b0, 1'b0, '0);
      chk("R6 plain February", snapshot, pack(0, 0, 0, 2, 1, 3, 1));
      ld(59, 59, 23, 1, 28, 2, 24);
      step(1'b1, 1'b0, 1'b0, '0);
      chk("R6 leap day 24", snapshot, pack(0, 0, 0, 2, 29, 2, 24));
      ld(59, 59, 23, 1, 29, 2, 24);
      step(1'b1, 1'b0, 1'b0, '0);
      chk("R6 leap February end", snapshot, pack(0, 0, 0, 2, 1, 3, 24));
      ld(59, 59, 23, 1, 28, 2, 0);
      step(1'b1, 1'b0, 1'b0, '0);
      chk("R6 year 00 leap", snapshot, pack(0, 0, 0, 2, 29, 2, 0));
      ld(59, 59, 23, 1, 28, 2, 96);
      step(1'b1, 1'b0, 1'b0, '0);
      chk("R6 year 96 leap", snapshot, pack(0, 0, 0, 2, 29, 2, 96));

      raw = pack(0, 0, 0, 1, 1, 1, 0);
      raw[6:0] = 7'h60;
      step(1'b0, 1'b0, 1'b1, raw);
      step(1'b1, 1'b0, 1'b0, '0);
      exp = raw; exp[6:0] = 7'h61;
      chk("R10 out of range seconds", snapshot, exp);

      spare = '0;
      spare[7] = 1'b1; spare[15] = 1'b1; spare[22] = 1'b1; spare[23] = 1'b1;
      spare[27] = 1'b1; spare[34] = 1'b1; spare[35] = 1'b1;
      spare[41] = 1'b1; spare[42] = 1'b1; spare[43] = 1'b1;
      step(1'b0, 1'b0, 1'b1, pack(12, 34, 5, 4, 17, 8, 55) | spare);
      chk("R2 spare bits ignored", snapshot, pack(12, 34, 5, 4, 17, 8, 55));

      for (int i = 0; i < 8000; i++) begin
         logic [51:0] w;
         logic t, f, l;
         l = ($urandom % 16) == 0;
         t = ($urandom % 4) != 0;
         f = ($urandom % 6) == 0;
         if (l) begin
            int y, mo, d, h, mi, s, wd, dm;
            y  = $urandom % 100;
            mo = 1 + $urandom % 12;
            dm = dim(mo, y);
            d  = ($urandom % 2) ? dm : 1 + $urandom % dm;
            h  = ($urandom % 2) ? 23 : $urandom % 24;
            mi = ($urandom % 2) ? 59 : $urandom % 60;
            s  = ($urandom % 3) ? 59 - $urandom % 2 : $urandom % 60;
            wd = 1 + $urandom % 7;
            w  = pack(s, mi, h, wd, d, mo, y);
         end else begin
            w = {20'($urandom), $urandom};
         end
         step(t, f, l, w);
         chk("R11 random run", snapshot, model_word());
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule